// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block forms the 32-bit byte address used by load, store and branch operations in a flat, unsegmented address space. Each cycle it may accept one request. A request carries a mode selector, a base register value, an index register value, a scale code, a signed 12-bit offset and the current instruction address. The unit combines the operands that the mode selects and returns one effective address with a matching valid flag.

The result is registered, so it appears one clock after the request is accepted. A scale code beyond the supported range in indexed mode raises an error flag and forces the address to zero. The unit does not decode instructions, read registers, access memory or check alignment.

Top module: `agu_core`

## Requirements
- R1: While rst_ni is low, valid_o, addr_o and bad_mode_o are all 0. This reset acts asynchronously.
- R2: valid_o is high in exactly the cycle after a cycle in which valid_i was sampled high at a rising clock edge, so the latency is one cycle.
- R3: mode_i = 2'b00 (register direct) gives addr_o = base_i. index_i, disp_i and ip_i have no effect in this mode.
- R4: mode_i = 2'b01 gives addr_o = base_i + disp_i. disp_i is a two's-complement value that is sign-extended from bit 11 to 32 bits.
- R5: mode_i = 2'b10 gives addr_o = base_i + (index_i << scale_i) + sign-extended disp_i. Scale codes 0, 1, 2, 3 and 4 multiply the index by 1, 2, 4, 8 and 16.
- R6: In mode 2'b10, a scale code of 5, 6 or 7 sets bad_mode_o to 1 and sets addr_o to 0.
- R7: mode_i = 2'b11 (relative to the instruction address) gives addr_o = ip_i + sign-extended disp_i. base_i and index_i have no effect in this mode.
- R8: Every sum, and the shifted index, wraps modulo 2^32. Bits carried out above bit 31 are dropped and no overflow is reported.
- R9: A cycle with valid_i low leaves addr_o and bad_mode_o unchanged.
- R10: In modes other than 2'b10, scale_i is ignored and bad_mode_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| mode_i | input | 2 | Address mode selector |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| scale_i | input | 3 | Index shift code |
| disp_i | input | 12 | Signed offset |
| ip_i | input | 32 | Current instruction address |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective address |
| bad_mode_o | output | 1 | Unsupported scale code in indexed mode |

## Verification
The only state in this block is the output register. A fault in it shows at the ports in the first cycle after the request that caused it. A wrong operand selection or a wrong shift shows as a wrong addr_o on the very next clock. A bad load enable shows as an address that moves during an idle cycle, or as one that fails to update on a new request. A wrong sign extension shows only when the offset is negative, and a wrong wrap shows only when a sum crosses 2^32, so the stimulus includes both cases in every mode that adds an offset.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DISP_W    = 12;
  localparam int unsigned SCALE_W   = 3;
  localparam int unsigned MAX_SHIFT = 4;

  typedef enum logic [1:0] {
    MODE_REG  = 2'b00,
    MODE_BD   = 2'b01,
    MODE_BISD = 2'b10,
    MODE_IPR  = 2'b11
  } agu_mode_e;
endpackage

// File: rtl/agu_scale.sv
module agu_scale #(
  parameter int unsigned W         = 32,
  parameter int unsigned SCALE_W   = 3,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic [W-1:0]       idx_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [W-1:0]       scaled_o,
  output logic               ok_o
);
  localparam int unsigned NCAND = MAX_SHIFT + 1;

  logic [W-1:0] cand [NCAND];

  for (genvar s = 0; s < NCAND; s++) begin : g_cand
    assign cand[s] = idx_i << s;
  end

  always_comb begin
    scaled_o = '0;
    for (int s = 0; s < NCAND; s++) begin
      if (scale_i == SCALE_W'(s)) scaled_o = cand[s];
    end
  end

  assign ok_o = (scale_i <= SCALE_W'(MAX_SHIFT));
endmodule

// File: rtl/agu_operand.sv
module agu_operand
  import agu_pkg::*;
#(
  parameter int unsigned W      = ADDR_W,
  parameter int unsigned DISP_W = agu_pkg::DISP_W
) (
  input  agu_mode_e         mode_i,
  input  logic [W-1:0]      base_i,
  input  logic [W-1:0]      scaled_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [W-1:0]      ip_i,
  output logic [W-1:0]      term_a_o,
  output logic [W-1:0]      term_b_o,
  output logic [W-1:0]      term_c_o
);
  localparam int unsigned EXT_W = W - DISP_W;

  logic [W-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    term_a_o = base_i;
    term_b_o = '0;
    term_c_o = '0;
    unique case (mode_i)
      MODE_REG:  ;
      MODE_BD:   term_c_o = disp_ext;
      MODE_BISD: begin
        term_b_o = scaled_i;
        term_c_o = disp_ext;
      end
      MODE_IPR: begin
        term_a_o = ip_i;
        term_c_o = disp_ext;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          mode_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]   index_i,
  input  logic [SCALE_W-1:0]  scale_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [ADDR_W-1:0]   ip_i,
  output logic                valid_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                bad_mode_o
);
  agu_mode_e        mode;
  logic [ADDR_W-1:0] scaled, term_a, term_b, term_c, sum;
  logic              scale_ok, bad_d;
  logic              valid_q, bad_q;
  logic [ADDR_W-1:0] addr_q;

  assign mode = agu_mode_e'(mode_i);

  agu_scale #(
    .W(ADDR_W), .SCALE_W(SCALE_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_scale (
    .idx_i   (index_i),
    .scale_i (scale_i),
    .scaled_o(scaled),
    .ok_o    (scale_ok)
  );

  agu_operand #(.W(ADDR_W), .DISP_W(DISP_W)) u_opnd (
    .mode_i  (mode),
    .base_i  (base_i),
    .scaled_i(scaled),
    .disp_i  (disp_i),
    .ip_i    (ip_i),
    .term_a_o(term_a),
    .term_b_o(term_b),
    .term_c_o(term_c)
  );

  // modulo 2^W by truncation
  assign sum   = term_a + term_b + term_c;
  assign bad_d = (mode == MODE_BISD) && !scale_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        addr_q <= bad_d ? '0 : sum;
        bad_q  <= bad_d;
      end
    end
  end

  assign valid_o    = valid_q;
  assign addr_o     = addr_q;
  assign bad_mode_o = bad_q;
endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         mode_i,
  input logic [ADDR_W-1:0]  base_i,
  input logic               valid_o,
  input logic [ADDR_W-1:0]  addr_o,
  input logic               bad_mode_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && addr_o == '0 && !bad_mode_o));

  assert_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i));

  assert_direct_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && $past(mode_i) == 2'b00)
      |-> (addr_o == $past(base_i)));

  assert_bad_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_mode_o |-> addr_o == '0);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> ($stable(addr_o) && $stable(bad_mode_o)));

  assert_scale_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i) && $past(mode_i) != 2'b10) |-> !bad_mode_o);
endmodule

bind agu_core agu_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .base_i    (base_i),
  .valid_o   (valid_o),
  .addr_o    (addr_o),
  .bad_mode_o(bad_mode_o)
);

// File: tb/sim_agu_core.sv
module sim_agu_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  localparam int VW = 2 + 3 + 32 + 32 + 12 + 32 + 32 + 1;

  // {mode, scale, base, index, disp, ip, exp_addr, exp_bad}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 32'h1234_5678, 32'hFFFF_FFFF, 12'h7FF, 32'h0000_0000, 32'h1234_5678, 1'b0}, // R3
    {2'd1, 3'd0, 32'h0000_1000, 32'h0000_DEAD, 12'h7FF, 32'h0000_0000, 32'h0000_17FF, 1'b0}, // R4
    {2'd1, 3'd0, 32'h0000_1000, 32'h0000_0000, 12'h800, 32'h0000_0000, 32'h0000_0800, 1'b0}, // R4
    {2'd1, 3'd0, 32'h0000_0005, 32'h0000_0000, 12'hFFF, 32'h0000_0000, 32'h0000_0004, 1'b0}, // R4
    {2'd2, 3'd0, 32'h0000_0100, 32'h0000_0010, 12'h000, 32'h0000_0000, 32'h0000_0110, 1'b0}, // R5
    {2'd2, 3'd1, 32'h0000_0100, 32'h0000_0010, 12'h004, 32'h0000_0000, 32'h0000_0124, 1'b0}, // R5
    {2'd2, 3'd2, 32'h0000_0100, 32'h0000_0010, 12'hFFC, 32'h0000_0000, 32'h0000_013C, 1'b0}, // R5
    {2'd2, 3'd3, 32'h0000_0000, 32'h0000_0010, 12'h000, 32'h0000_0000, 32'h0000_0080, 1'b0}, // R5
    {2'd2, 3'd4, 32'h0000_1000, 32'h0000_0003, 12'h001, 32'h0000_0000, 32'h0000_1031, 1'b0}, // R5
    {2'd2, 3'd5, 32'h0000_1000, 32'h0000_0003, 12'h001, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R6
    {2'd2, 3'd7, 32'h0000_1000, 32'h0000_0003, 12'h001, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R6
    {2'd3, 3'd0, 32'h0000_FFFF, 32'h0000_0000, 12'h010, 32'h0000_2000, 32'h0000_2010, 1'b0}, // R7
    {2'd3, 3'd0, 32'h0000_0000, 32'h0000_0000, 12'h800, 32'h0000_0400, 32'hFFFF_FC00, 1'b0}, // R7 R8
    {2'd1, 3'd0, 32'hFFFF_FFF0, 32'h0000_0000, 12'h020, 32'h0000_0000, 32'h0000_0010, 1'b0}, // R8
    {2'd2, 3'd4, 32'hF000_0000, 32'h1000_0000, 12'h7FF, 32'h0000_0000, 32'hF000_07FF, 1'b0}, // R8
    {2'd0, 3'd6, 32'hCAFE_F00D, 32'h0000_0001, 12'h123, 32'h0000_0000, 32'hCAFE_F00D, 1'b0}, // R10
    {2'd3, 3'd5, 32'h0000_0000, 32'h0000_0000, 12'h000, 32'h0000_0100, 32'h0000_0100, 1'b0}  // R10
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] base_i = '0, index_i = '0, ip_i = '0;
  logic [2:0]  scale_i = '0;
  logic [11:0] disp_i = '0;
  logic        valid_o, bad_mode_o;
  logic [31:0] addr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  agu_core u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .base_i(base_i), .index_i(index_i), .scale_i(scale_i), .disp_i(disp_i),
    .ip_i(ip_i), .valid_o(valid_o), .addr_o(addr_o), .bad_mode_o(bad_mode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    {mode_i, scale_i, base_i, index_i, disp_i, ip_i} = v[VW-1:33];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 valid", {31'd0, valid_o}, 32'd0);
    check("R1 addr", addr_o, 32'd0);
    check("R1 bad", {31'd0, bad_mode_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R2 idle", {31'd0, valid_o}, 32'd0);

    // table walk, back-to-back requests
    valid_i = 1'b1;
    drive(VEC[0]);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      check($sformatf("R2 vec%0d valid", i), {31'd0, valid_o}, 32'd1);
      check($sformatf("vec%0d addr", i), addr_o, VEC[i][32:1]);
      check($sformatf("vec%0d bad", i), {31'd0, bad_mode_o}, {31'd0, VEC[i][0]});
      if (i + 1 < NVEC) drive(VEC[i + 1]);
    end

    // R9: idle cycle with changed inputs holds result
    valid_i = 1'b0;
    mode_i = 2'd1; base_i = 32'h5555_0000; disp_i = 12'h111;
    @(negedge clk_i);
    check("R2 drop", {31'd0, valid_o}, 32'd0);
    check("R9 hold addr", addr_o, 32'h0000_0100);
    @(negedge clk_i);
    check("R9 hold addr2", addr_o, 32'h0000_0100);

    // R6 then R9: error result held across idle
    valid_i = 1'b1; mode_i = 2'd2; scale_i = 3'd6; base_i = 32'h1; index_i = 32'h1;
    @(negedge clk_i);
    check("R6 scale6 bad", {31'd0, bad_mode_o}, 32'd1);
    check("R6 scale6 addr", addr_o, 32'd0);
    valid_i = 1'b0; scale_i = 3'd0;
    @(negedge clk_i);
    check("R9 hold bad", {31'd0, bad_mode_o}, 32'd1);

    // R3: direct mode ignores ip, index and disp
    valid_i = 1'b1; mode_i = 2'd0; base_i = 32'h0BAD_BEEF;
    index_i = 32'hFFFF_FFFF; disp_i = 12'hFFF; ip_i = 32'h8000_0000;
    @(negedge clk_i);
    check("R3 ignore", addr_o, 32'h0BAD_BEEF);
    check("R10 direct bad", {31'd0, bad_mode_o}, 32'd0);

    // R1: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async valid", {31'd0, valid_o}, 32'd0);
    check("R1 async addr", addr_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    valid_i = 1'b0;
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule